// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block performs the state transfer a 32-bit embedded CPU makes when it enters an exception or interrupt handler. The core presents a request strobe together with its current status word, program counter, stack register (R15), vector base, delay-slot flags and sleep flag. It also presents any pending exception code and a hard-interrupt request. An external priority controller supplies an interrupt vector. The block computes this vector from the interrupt mask that the sequencer exports from the status word.

In the accept cycle the block decides whether an entry happens and what kind it is. On the next clock edge it writes the saved status, saved PC and saved stack register. On the same edge it writes the new status word, the exception or interrupt event code and the handler address. It then raises a one-cycle `taken_o` pulse. All results hold until a later request changes them. A blocked status word turns most exceptions into a reset and masks interrupts unless the core sleeps. The saved PC is rewound for a branch delay slot and advanced for the trap instruction.

Top module: `exc_entry_seq`

## Requirements
- R1: A pending exception (`exc_pend_i`=1) wins over an interrupt request in the same cycle: `expevt_o` takes the exception code and `intevt_o` is left unchanged.
- R2: When the block bit (status bit 28) is set, a pending exception with any code other than 0x1E0 is taken as code 0x000 (reset). Code 0x1E0 is taken unchanged.
- R3: When the block bit is set and the core is not sleeping, an interrupt request is ignored: no `taken_o` pulse, and every saved register, event code and `pc_o` keeps its value.
- R4: `irq_mask_o` always equals status bits 7:4. An interrupt with `irq_vec_valid_i`=0 causes no entry.
- R5: On an entry, `ssr_o` takes the old status word, `sgr_o` takes R15, and `sr_o` is the old status with bits 28, 29 and 30 set.
- R6: If flag bit 0 or bit 1 is set, `spc_o` is the PC minus 2 and flag bits 2:0 are cleared. If flag bit 3 is set, all four flags become 0. Otherwise `spc_o` is the PC.
- R7: Exception codes 0x000, 0x020 and 0x140 also clear status bit 15, set status bits 7:4 to 0xF, and give `pc_o` = 0xA0000000.
- R8: Exception codes 0x040 and 0x060 give `pc_o` = VBR+0x400. Every other exception code gives VBR+0x100. Code 0x160 additionally adds 2 to `spc_o`, after any delay-slot rewind.
- R9: An accepted interrupt writes the vector to `intevt_o`, gives `pc_o` = VBR+0x600, and leaves `expevt_o` unchanged.
- R10: Reset clears all outputs. `taken_o` is high for exactly the cycle after an accepted request. On any request, `sleep_o` becomes 0 if the entry is accepted and otherwise copies `sleep_i`. `flags_o` follows the same pattern: it takes the new flags if accepted and otherwise copies `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Entry evaluation strobe |
| exc_pend_i | input | 1 | An exception code is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | Hard-interrupt request |
| irq_vec_valid_i | input | 1 | Controller returned a vector |
| irq_vec_i | input | 12 | Interrupt vector from controller |
| irq_mask_o | output | 4 | Interrupt mask presented to controller |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current PC |
| r15_i | input | 32 | Current R15 |
| vbr_i | input | 32 | Vector base |
| flags_i | input | 4 | Delay-slot flags |
| sleep_i | input | 1 | Core is sleeping |
| taken_o | output | 1 | One-cycle entry pulse |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved PC |
| sgr_o | output | 32 | Saved R15 |
| sr_o | output | 32 | New status word |
| expevt_o | output | 12 | Exception event code |
| intevt_o | output | 12 | Interrupt event code |
| pc_o | output | 32 | Handler address |
| flags_o | output | 4 | Updated flags |
| sleep_o | output | 1 | Updated sleep flag |

## Verification
Two collisions are the focus. The first is an exception and an interrupt arriving in the same request. The second is the blocked status combined with the sleep flag, which decides whether an interrupt is masked or woken. The bench provokes both with directed requests, then with random mixes in which the pending flag, the interrupt request, the block bit and the sleep flag are each drawn independently. A further collision is a trap taken from a delay slot, where the rewind and the trap advance cancel. Each outcome is judged against a bench model: the bench predicts which event code moves, which one stays, and whether a pulse appears at all.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned SR_FD_BIT = 15;
  localparam int unsigned SR_BL_BIT = 28;
  localparam int unsigned SR_RB_BIT = 29;
  localparam int unsigned SR_MD_BIT = 30;
  localparam int unsigned IMASK_LO  = 4;
  localparam int unsigned IMASK_W   = 4;

  localparam logic [11:0] CODE_POWER_RST  = 12'h000;
  localparam logic [11:0] CODE_MANUAL_RST = 12'h020;
  localparam logic [11:0] CODE_MULTI_HIT  = 12'h140;
  localparam logic [11:0] CODE_MISS_RD    = 12'h040;
  localparam logic [11:0] CODE_MISS_WR    = 12'h060;
  localparam logic [11:0] CODE_TRAP       = 12'h160;
  localparam logic [11:0] CODE_BL_EXEMPT  = 12'h1E0;

  typedef enum logic [1:0] {
    ENTRY_NONE = 2'd0,
    ENTRY_EXC  = 2'd1,
    ENTRY_IRQ  = 2'd2
  } entry_kind_e;

  typedef enum logic [1:0] {
    VEC_RESET   = 2'd0,
    VEC_MISS    = 2'd1,
    VEC_GENERAL = 2'd2,
    VEC_IRQ     = 2'd3
  } vec_class_e;
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_entry_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              exc_pend_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_vec_valid_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  input  logic              blocked_i,
  input  logic              sleep_i,
  output entry_kind_e       kind_o,
  output logic [CODE_W-1:0] code_o
);
  logic exempt;
  logic irq_ok;

  assign exempt = (exc_code_i == CODE_W'(CODE_BL_EXEMPT));
  // sleeping core may be woken even while blocked
  assign irq_ok = irq_req_i && irq_vec_valid_i && (!blocked_i || sleep_i);

  always_comb begin
    kind_o = ENTRY_NONE;
    code_o = '0;
    if (exc_pend_i) begin
      kind_o = ENTRY_EXC;
      code_o = (blocked_i && !exempt) ? CODE_W'(CODE_POWER_RST) : exc_code_i;
    end else if (irq_ok) begin
      kind_o = ENTRY_IRQ;
      code_o = irq_vec_i;
    end
  end
endmodule

// File: rtl/exc_entry_ctx.sv
module exc_entry_ctx
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned FLAG_W = 4
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              is_trap_i,
  output logic [XLEN-1:0]   spc_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(2);

  logic in_slot;
  logic [XLEN-1:0] rewound;

  assign in_slot = flags_i[0] | flags_i[1];
  assign rewound = in_slot ? (pc_i - INSN_BYTES) : pc_i;
  assign spc_o   = is_trap_i ? (rewound + INSN_BYTES) : rewound;

  always_comb begin
    flags_o = flags_i;
    if (in_slot) flags_o[2:0] = 3'b000;
    if (flags_i[3]) flags_o = '0;
  end
endmodule

// File: rtl/exc_entry_vec.sv
module exc_entry_vec
  import exc_entry_pkg::*;
#(
  parameter int unsigned    XLEN      = 32,
  parameter int unsigned    CODE_W    = 12,
  parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [XLEN-1:0] OFS_MISS = 32'h0000_0400,
  parameter logic [XLEN-1:0] OFS_IRQ  = 32'h0000_0600
) (
  input  entry_kind_e       kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   vbr_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic              is_trap_o
);
  vec_class_e vclass;

  always_comb begin
    vclass = VEC_GENERAL;
    if (kind_i == ENTRY_IRQ) begin
      vclass = VEC_IRQ;
    end else begin
      unique case (code_i)
        CODE_W'(CODE_POWER_RST),
        CODE_W'(CODE_MANUAL_RST),
        CODE_W'(CODE_MULTI_HIT): vclass = VEC_RESET;
        CODE_W'(CODE_MISS_RD),
        CODE_W'(CODE_MISS_WR):   vclass = VEC_MISS;
        default:                 vclass = VEC_GENERAL;
      endcase
    end
  end

  assign is_trap_o = (kind_i == ENTRY_EXC) && (code_i == CODE_W'(CODE_TRAP));

  always_comb begin
    sr_o = sr_i;
    sr_o[SR_BL_BIT] = 1'b1;
    sr_o[SR_RB_BIT] = 1'b1;
    sr_o[SR_MD_BIT] = 1'b1;
    unique case (vclass)
      VEC_RESET: begin
        sr_o[SR_FD_BIT] = 1'b0;
        sr_o[IMASK_LO +: IMASK_W] = '1;
        pc_o = RESET_PC;
      end
      VEC_MISS: pc_o = vbr_i + OFS_MISS;
      VEC_IRQ:  pc_o = vbr_i + OFS_IRQ;
      default:  pc_o = vbr_i + OFS_GEN;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned FLAG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              exc_pend_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_vec_valid_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  output logic [IMASK_W-1:0] irq_mask_o,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              sleep_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              sleep_o
);
  entry_kind_e       kind;
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   spc_n, pc_n, sr_n;
  logic [FLAG_W-1:0] flags_n;
  logic              is_trap;
  logic              accept;

  assign irq_mask_o = sr_i[IMASK_LO +: IMASK_W];

  exc_entry_arb #(.CODE_W(CODE_W)) u_arb (
    .exc_pend_i      (exc_pend_i),
    .exc_code_i      (exc_code_i),
    .irq_req_i       (irq_req_i),
    .irq_vec_valid_i (irq_vec_valid_i),
    .irq_vec_i       (irq_vec_i),
    .blocked_i       (sr_i[SR_BL_BIT]),
    .sleep_i         (sleep_i),
    .kind_o          (kind),
    .code_o          (code)
  );

  exc_entry_vec #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .kind_i    (kind),
    .code_i    (code),
    .sr_i      (sr_i),
    .vbr_i     (vbr_i),
    .pc_o      (pc_n),
    .sr_o      (sr_n),
    .is_trap_o (is_trap)
  );

  exc_entry_ctx #(.XLEN(XLEN), .FLAG_W(FLAG_W)) u_ctx (
    .pc_i      (pc_i),
    .flags_i   (flags_i),
    .is_trap_i (is_trap),
    .spc_o     (spc_n),
    .flags_o   (flags_n)
  );

  assign accept = req_i && (kind != ENTRY_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o  <= 1'b0;
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      sr_o     <= '0;
      expevt_o <= '0;
      intevt_o <= '0;
      pc_o     <= '0;
      flags_o  <= '0;
      sleep_o  <= 1'b0;
    end else begin
      taken_o <= accept;
      if (req_i) begin
        sleep_o <= accept ? 1'b0 : sleep_i;
        flags_o <= accept ? flags_n : flags_i;
      end
      if (accept) begin
        ssr_o <= sr_i;
        spc_o <= spc_n;
        sgr_o <= r15_i;
        sr_o  <= sr_n;
        pc_o  <= pc_n;
        if (kind == ENTRY_EXC) expevt_o <= code;
        else                   intevt_o <= code;
      end
    end
  end

  a_r1_exc_keeps_intevt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && $past(exc_pend_i) |-> $stable(intevt_o));

  a_r2_blocked_to_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && $past(exc_pend_i) && $past(sr_i[SR_BL_BIT])
      && ($past(exc_code_i) != CODE_W'(CODE_BL_EXEMPT))
    |-> (expevt_o == '0) && (pc_o == 32'hA000_0000));

  a_r5_status_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> sr_o[SR_BL_BIT] && sr_o[SR_RB_BIT] && sr_o[SR_MD_BIT]);

  a_r9_irq_keeps_expevt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && !$past(exc_pend_i) |-> $stable(expevt_o) && (pc_o == $past(vbr_i) + 32'h600));

  a_r10_taken_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> $past(req_i));

  a_r10_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> $stable(pc_o) && $stable(spc_o) && $stable(ssr_o));

  a_r10_sleep_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> !sleep_o);
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req, exc_pend, irq_req, vec_valid, sleep;
  logic [11:0] exc_code, irq_vec;
  logic [31:0] sr, pc, r15, vbr;
  logic [3:0]  flags;
  logic [3:0]  irq_mask;
  logic        taken, sleep_q;
  logic [31:0] ssr, spc, sgr, sr_q, pc_q;
  logic [11:0] expevt, intevt;
  logic [3:0]  flags_q;

  exc_entry_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .exc_pend_i(exc_pend), .exc_code_i(exc_code),
    .irq_req_i(irq_req), .irq_vec_valid_i(vec_valid), .irq_vec_i(irq_vec), .irq_mask_o(irq_mask),
    .sr_i(sr), .pc_i(pc), .r15_i(r15), .vbr_i(vbr), .flags_i(flags), .sleep_i(sleep),
    .taken_o(taken), .ssr_o(ssr), .spc_o(spc), .sgr_o(sgr), .sr_o(sr_q), .expevt_o(expevt),
    .intevt_o(intevt), .pc_o(pc_q), .flags_o(flags_q), .sleep_o(sleep_q)
  );

  int checks = 0, errors = 0;
  logic        e_taken, e_sleep;
  logic [31:0] e_ssr, e_spc, e_sgr, e_sr, e_pc;
  logic [11:0] e_exp, e_int;
  logic [3:0]  e_flags;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model();
    logic acc, is_exc;
    logic [11:0] c;
    logic [31:0] s, sp;
    logic [3:0] f;
    acc = 1'b0; is_exc = 1'b0; c = exc_code;
    if (exc_pend) begin
      acc = 1'b1; is_exc = 1'b1;
      if (sr[28] && exc_code != 12'h1E0) c = 12'h000;
    end else if (irq_req && vec_valid && (!sr[28] || sleep)) begin
      acc = 1'b1;
    end
    e_taken = acc;
    if (!acc) begin
      e_sleep = sleep; e_flags = flags;
    end else begin
      e_sleep = 1'b0;
      e_ssr = sr; e_sgr = r15;
      sp = pc; f = flags;
      if (f[0] | f[1]) begin sp = sp - 2; f[2:0] = 3'b0; end
      if (f[3]) f = 4'h0;
      s = sr | 32'h7000_0000;
      if (is_exc) begin
        e_exp = c;
        if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin
          s[15] = 1'b0; s[7:4] = 4'hF; e_pc = 32'hA000_0000;
        end else if (c == 12'h040 || c == 12'h060) begin
          e_pc = vbr + 32'h400;
        end else begin
          if (c == 12'h160) sp = sp + 2;
          e_pc = vbr + 32'h100;
        end
      end else begin
        e_int = irq_vec; e_pc = vbr + 32'h600;
      end
      e_spc = sp; e_sr = s; e_flags = f;
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R10 taken"}, {31'b0, taken}, {31'b0, e_taken});
    chk({tag, " R5 ssr"}, ssr, e_ssr);
    chk({tag, " R6 spc"}, spc, e_spc);
    chk({tag, " R5 sgr"}, sgr, e_sgr);
    chk({tag, " R5 sr"}, sr_q, e_sr);
    chk({tag, " R1 expevt"}, {20'b0, expevt}, {20'b0, e_exp});
    chk({tag, " R9 intevt"}, {20'b0, intevt}, {20'b0, e_int});
    chk({tag, " R8 pc"}, pc_q, e_pc);
    chk({tag, " R6 flags"}, {28'b0, flags_q}, {28'b0, e_flags});
    chk({tag, " R10 sleep"}, {31'b0, sleep_q}, {31'b0, e_sleep});
  endtask

  task automatic step(string tag);
    req = 1'b1;
    #1;
    chk({tag, " R4 mask"}, {28'b0, irq_mask}, {28'b0, sr[7:4]});
    model();
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    check_all(tag);
  endtask

  task automatic setup(logic ep, logic [11:0] ec, logic ir, logic vv, logic [11:0] iv,
                       logic [31:0] s, logic [3:0] f, logic sl);
    exc_pend = ep; exc_code = ec; irq_req = ir; vec_valid = vv; irq_vec = iv;
    sr = s; flags = f; sleep = sl;
    pc = 32'h0C00_1000 + {$urandom} % 32'h1000 * 2;
    r15 = $urandom; vbr = $urandom & 32'hFFFF_F000;
  endtask

  function automatic logic [11:0] pick_code(int unsigned i);
    case (i % 11)
      0: return 12'h000;  1: return 12'h020;  2: return 12'h140;
      3: return 12'h040;  4: return 12'h060;  5: return 12'h160;
      6: return 12'h1E0;  7: return 12'h0A0;  8: return 12'h180;
      9: return 12'h800;  default: return 12'h0E0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    req = 0; exc_pend = 0; irq_req = 0; vec_valid = 0; sleep = 0;
    exc_code = 0; irq_vec = 0; sr = 0; pc = 0; r15 = 0; vbr = 0; flags = 0;
    e_taken = 0; e_sleep = 0; e_ssr = 0; e_spc = 0; e_sgr = 0; e_sr = 0; e_pc = 0;
    e_exp = 0; e_int = 0; e_flags = 0;
    repeat (3) @(negedge clk);
    check_all("reset R10");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: exception and interrupt together
    setup(1, 12'h180, 1, 1, 12'h3A0, 32'h0000_00F0, 4'h0, 0); step("R1 collide");
    // R9: plain interrupt
    setup(0, 12'h000, 1, 1, 12'h320, 32'h0000_0030, 4'h0, 0); step("R9 irq");
    // R2: blocked exceptions
    setup(1, 12'h0A0, 0, 0, 12'h0, 32'h1000_8000, 4'h0, 0); step("R2 blocked");
    setup(1, 12'h1E0, 0, 0, 12'h0, 32'h1000_0000, 4'h0, 0); step("R2 exempt");
    // R3: blocked interrupt, awake then sleeping
    setup(0, 12'h0, 1, 1, 12'h400, 32'h1000_0000, 4'h5, 1'b0); step("R3 masked");
    setup(0, 12'h0, 1, 1, 12'h420, 32'h1000_0000, 4'h0, 1'b1); step("R3 wake");
    // R4: no vector returned
    setup(0, 12'h0, 1, 0, 12'h440, 32'h0000_0050, 4'h2, 1'b1); step("R4 novec");
    // R6 and R8: trap from a delay slot, clear-me flag
    setup(1, 12'h160, 0, 0, 12'h0, 32'h0000_0000, 4'h5, 0); step("R8 trap slot");
    setup(1, 12'h800, 0, 0, 12'h0, 32'h0000_0000, 4'hA, 0); step("R6 clearme");
    setup(1, 12'h060, 0, 0, 12'h0, 32'h0000_0000, 4'h4, 0); step("R8 miss");
    // R7: reset-class code
    setup(1, 12'h140, 0, 0, 12'h0, 32'h0000_8000, 4'h0, 0); step("R7 rstclass");
    // R10: idle cycle holds
    e_taken = 1'b0;
    @(negedge clk); check_all("R10 idle");

    for (int i = 0; i < 600; i++) begin
      setup($urandom % 2, pick_code($urandom), $urandom % 2, ($urandom % 4) != 0,
            12'h200 + 12'h020 * ($urandom % 16), $urandom, $urandom, $urandom % 2);
      step("rand");
      if ($urandom % 4 == 0) begin
        e_taken = 1'b0;
        @(negedge clk); check_all("rand R10 idle");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule